// File: doc/BRIEF.md
# Slot-Port Network Interrupt Aggregator

This block gathers network interrupt requests from seven adapter slots, each with up to eight ports, into two 32-bit status words. Each slot is given one byte lane of one status word. The assignment of slots to lanes is fixed and irregular. Adapter-side logic raises or drops a request by giving a slot number and a port number on a set channel or a clear channel. The bus never changes a status bit.

Software uses a small word-wide register bus. It can read either status word and read or write two mask words, one per status word. The block drives a single level-sensitive interrupt line. That line is high whenever some status bit is set and the matching mask bit is also set. The line comes from a register, so it follows any change of status or mask one clock later. Read data is also registered and appears on the cycle after the read strobe.

Top module: `netirq_aggregator`

## Requirements
- R1: Status word 0 holds slot 0 in bits 7:0, slot 1 in bits 15:8, slot 4 in bits 23:16 and slot 3 in bits 31:24.
- R2: Status word 1 holds slot 2 in bits 15:8, slot 6 in bits 23:16 and slot 5 in bits 31:24. Its bits 7:0 always read as zero.
- R3: A set request for slot s and port p (0..7) sets bit (lane base of s + p) in the word that holds slot s. A clear request clears that bit. If set and clear name the same bit in one cycle, the set wins. Requests naming different bits in one cycle both take effect.
- R4: A request whose slot number is 7 changes no status bit.
- R5: Reading any address 0x10..0x13 returns status word 0, and reading any address 0x18..0x1B returns status word 1. Bus writes to these addresses change no status bit.
- R6: Mask word 0 is read and written at address 0x20, and mask word 1 at address 0x28. A written value reads back unchanged.
- R7: The interrupt output is 1 exactly one cycle after the registered state satisfies ((status0 & mask0) | (status1 & mask1)) != 0, and 0 otherwise.
- R8: After reset, both status words and both mask words are zero and the interrupt output is 0.
- R9: A read of any other address returns zero, including 0x21 and 0x29.
- R10: Read data appears on bus_rdata on the cycle after bus_re is sampled high, and shows the register contents as they were before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_vld | input | 1 | Set request valid |
| set_slot | input | 3 | Slot of the set request |
| set_port | input | 3 | Port of the set request |
| clr_vld | input | 1 | Clear request valid |
| clr_slot | input | 3 | Slot of the clear request |
| clr_port | input | 3 | Port of the clear request |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions check on every cycle that the interrupt line tracks the masked status of the previous cycle, and that a set or a clear lands on its bit with set priority. They also check that status holds when no valid request arrives (so out-of-range slots and bus writes cannot touch it), that lane 0 of word 1 stays empty, that mask writes land, and that unmapped reads return zero. Only the bench scenarios can show that each slot reaches the right byte lane, because they read the status words back through the bus. The same holds for the status aliases across four addresses and for the reset values seen at the ports.

// File: rtl/netirq_pkg.sv
package netirq_pkg;

    localparam int WORD_W    = 32;
    localparam int LANE_W    = 8;
    localparam int NUM_WORDS = 2;
    localparam int NUM_SLOTS = 7;
    localparam int SLOT_W    = 3;
    localparam int PORT_W    = $clog2(LANE_W);
    localparam int ADDR_W    = 8;

    localparam logic [ADDR_W-1:0] ADR_STAT0 = 8'h10;
    localparam logic [ADDR_W-1:0] ADR_STAT1 = 8'h18;
    localparam logic [ADDR_W-1:0] ADR_MASK0 = 8'h20;
    localparam logic [ADDR_W-1:0] ADR_MASK1 = 8'h28;

    // Which status word a slot lives in.
    function automatic logic slot_word(input logic [SLOT_W-1:0] slot);
        case (slot)
            3'd2, 3'd5, 3'd6: slot_word = 1'b1;
            default:          slot_word = 1'b0;
        endcase
    endfunction

    // Which byte lane inside that word a slot owns.
    function automatic logic [1:0] slot_lane(input logic [SLOT_W-1:0] slot);
        case (slot)
            3'd0:       slot_lane = 2'd0;
            3'd1, 3'd2: slot_lane = 2'd1;
            3'd4, 3'd6: slot_lane = 2'd2;
            default:    slot_lane = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/netirq_lane_decode.sv
module netirq_lane_decode
    import netirq_pkg::*;
#(
    parameter int P_WORD_W    = WORD_W,
    parameter int P_LANE_W    = LANE_W,
    parameter int P_NUM_WORDS = NUM_WORDS,
    parameter int P_NUM_SLOTS = NUM_SLOTS,
    parameter int P_SLOT_W    = SLOT_W,
    parameter int P_PORT_W    = PORT_W
) (
    input  logic                                   vld,
    input  logic [P_SLOT_W-1:0]                    slot,
    input  logic [P_PORT_W-1:0]                    port,
    output logic [P_NUM_WORDS-1:0][P_WORD_W-1:0]   hit
);

    localparam int BIT_W = $clog2(P_WORD_W);

    logic                 word_sel;
    logic [BIT_W-1:0]     bit_idx;
    logic                 in_range;

    always_comb begin
        word_sel = slot_word(slot);
        bit_idx  = BIT_W'(slot_lane(slot)) * BIT_W'(P_LANE_W) + BIT_W'(port);
        in_range = (32'(slot) < P_NUM_SLOTS);
        hit      = '0;
        for (int w = 0; w < P_NUM_WORDS; w++) begin
            if (vld && in_range && (w == int'(word_sel))) begin
                hit[w][bit_idx] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/netirq_status_bank.sv
module netirq_status_bank
    import netirq_pkg::*;
#(
    parameter int P_WORD_W    = WORD_W,
    parameter int P_LANE_W    = LANE_W,
    parameter int P_NUM_WORDS = NUM_WORDS
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [P_NUM_WORDS-1:0][P_WORD_W-1:0] set_hit,
    input  logic [P_NUM_WORDS-1:0][P_WORD_W-1:0] clr_hit,
    output logic [P_NUM_WORDS-1:0][P_WORD_W-1:0] status_q
);

    typedef struct packed {
        logic [P_NUM_WORDS-1:0][P_WORD_W-1:0] st;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int w = 0; w < P_NUM_WORDS; w++) begin
            // clear first, then set: set has priority on a shared bit
            bank_d.st[w] = (bank_q.st[w] & ~clr_hit[w]) | set_hit[w];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign status_q = bank_q.st;

    a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_hit) |=> ((status_q & $past(set_hit)) == $past(set_hit)));

    a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_hit & ~set_hit)) |=> ((status_q & $past(clr_hit & ~set_hit)) == '0));

    a_r5_hold_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|set_hit) && !(|clr_hit)) |=> $stable(status_q));

    a_r2_word1_lane0_empty: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[1][P_LANE_W-1:0] == '0);

endmodule

// File: rtl/netirq_regs.sv
module netirq_regs
    import netirq_pkg::*;
#(
    parameter int P_WORD_W    = WORD_W,
    parameter int P_NUM_WORDS = NUM_WORDS,
    parameter int P_ADDR_W    = ADDR_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [P_ADDR_W-1:0]                  bus_addr,
    input  logic                                 bus_we,
    input  logic                                 bus_re,
    input  logic [P_WORD_W-1:0]                  bus_wdata,
    input  logic [P_NUM_WORDS-1:0][P_WORD_W-1:0] status,
    output logic [P_NUM_WORDS-1:0][P_WORD_W-1:0] mask_q,
    output logic [P_WORD_W-1:0]                  rdata_q
);

    typedef struct packed {
        logic [P_NUM_WORDS-1:0][P_WORD_W-1:0] mask;
        logic [P_WORD_W-1:0]                  rdata;
    } regs_t;

    regs_t regs_d, regs_q;

    logic hit_st0, hit_st1, hit_mk0, hit_mk1, mapped;

    always_comb begin
        // status words alias over a 4-byte window
        hit_st0 = (bus_addr[P_ADDR_W-1:2] == ADR_STAT0[P_ADDR_W-1:2]);
        hit_st1 = (bus_addr[P_ADDR_W-1:2] == ADR_STAT1[P_ADDR_W-1:2]);
        hit_mk0 = (bus_addr == ADR_MASK0);
        hit_mk1 = (bus_addr == ADR_MASK1);
        mapped  = hit_st0 | hit_st1 | hit_mk0 | hit_mk1;
    end

    always_comb begin
        regs_d = regs_q;
        if (bus_we && hit_mk0) regs_d.mask[0] = bus_wdata;
        if (bus_we && hit_mk1) regs_d.mask[1] = bus_wdata;
        if (bus_re) begin
            unique case (1'b1)
                hit_st0: regs_d.rdata = status[0];
                hit_st1: regs_d.rdata = status[1];
                hit_mk0: regs_d.rdata = regs_q.mask[0];
                hit_mk1: regs_d.rdata = regs_q.mask[1];
                default: regs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mask_q  = regs_q.mask;
    assign rdata_q = regs_q.rdata;

    a_r6_mask0_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_MASK0) |=> (mask_q[0] == $past(bus_wdata)));

    a_r6_mask1_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_MASK1) |=> (mask_q[1] == $past(bus_wdata)));

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !mapped) |=> (rdata_q == '0));

endmodule

// File: rtl/netirq_aggregator.sv
module netirq_aggregator
    import netirq_pkg::*;
#(
    parameter int P_WORD_W    = WORD_W,
    parameter int P_LANE_W    = LANE_W,
    parameter int P_NUM_SLOTS = NUM_SLOTS,
    parameter int P_SLOT_W    = SLOT_W,
    parameter int P_PORT_W    = PORT_W,
    parameter int P_ADDR_W    = ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_vld,
    input  logic [P_SLOT_W-1:0]  set_slot,
    input  logic [P_PORT_W-1:0]  set_port,
    input  logic                 clr_vld,
    input  logic [P_SLOT_W-1:0]  clr_slot,
    input  logic [P_PORT_W-1:0]  clr_port,
    input  logic [P_ADDR_W-1:0]  bus_addr,
    input  logic                 bus_we,
    input  logic                 bus_re,
    input  logic [P_WORD_W-1:0]  bus_wdata,
    output logic [P_WORD_W-1:0]  bus_rdata,
    output logic                 irq
);

    localparam int NW = NUM_WORDS;

    logic [NW-1:0][P_WORD_W-1:0] set_hit, clr_hit, status_w, mask_w;

    netirq_lane_decode #(
        .P_WORD_W(P_WORD_W), .P_LANE_W(P_LANE_W), .P_NUM_WORDS(NW),
        .P_NUM_SLOTS(P_NUM_SLOTS), .P_SLOT_W(P_SLOT_W), .P_PORT_W(P_PORT_W)
    ) u_set_dec (
        .vld(set_vld), .slot(set_slot), .port(set_port), .hit(set_hit)
    );

    netirq_lane_decode #(
        .P_WORD_W(P_WORD_W), .P_LANE_W(P_LANE_W), .P_NUM_WORDS(NW),
        .P_NUM_SLOTS(P_NUM_SLOTS), .P_SLOT_W(P_SLOT_W), .P_PORT_W(P_PORT_W)
    ) u_clr_dec (
        .vld(clr_vld), .slot(clr_slot), .port(clr_port), .hit(clr_hit)
    );

    netirq_status_bank #(
        .P_WORD_W(P_WORD_W), .P_LANE_W(P_LANE_W), .P_NUM_WORDS(NW)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .set_hit(set_hit), .clr_hit(clr_hit), .status_q(status_w)
    );

    netirq_regs #(
        .P_WORD_W(P_WORD_W), .P_NUM_WORDS(NW), .P_ADDR_W(P_ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .status(status_w),
        .mask_q(mask_w), .rdata_q(bus_rdata)
    );

    typedef struct packed {
        logic irq;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        out_d.irq = 1'b0;
        for (int w = 0; w < NW; w++) begin
            out_d.irq = out_d.irq | (|(status_w[w] & mask_w[w]));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq = out_q.irq;

    a_r7_irq_tracks_masked: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|((status_w[0] & mask_w[0]) | (status_w[1] & mask_w[1])))));

    a_r4_bad_slot_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vld && 32'(set_slot) >= P_NUM_SLOTS && !clr_vld) |=> $stable(status_w));

endmodule

// File: tb/netirq_aggregator_tb.sv
module netirq_aggregator_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_vld = 0, clr_vld = 0;
    logic [2:0]  set_slot = 0, set_port = 0, clr_slot = 0, clr_port = 0;
    logic [7:0]  bus_addr = 0;
    logic        bus_we = 0, bus_re = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_st [2];
    logic [31:0] m_mk [2];

    always #10 clk = ~clk;  // 50 MHz

    netirq_aggregator u_dut (
        .clk(clk), .rst_n(rst_n),
        .set_vld(set_vld), .set_slot(set_slot), .set_port(set_port),
        .clr_vld(clr_vld), .clr_slot(clr_slot), .clr_port(clr_port),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic int word_of(int s);
        return (s == 2 || s == 5 || s == 6) ? 1 : 0;
    endfunction

    function automatic int base_of(int s);
        case (s)
            0: return 0;
            1, 2: return 8;
            4, 6: return 16;
            default: return 24;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        if (a[7:2] == 6'h04) return m_st[0];
        if (a[7:2] == 6'h06) return m_st[1];
        if (a == 8'h20) return m_mk[0];
        if (a == 8'h28) return m_mk[1];
        return 32'h0;
    endfunction

    function automatic logic exp_irq();
        return |((m_st[0] & m_mk[0]) | (m_st[1] & m_mk[1]));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // one request cycle, then model update
    task automatic request(logic sv, int ss, int sp, logic cv, int cs, int cp);
        @(negedge clk);
        set_vld = sv; set_slot = 3'(ss); set_port = 3'(sp);
        clr_vld = cv; clr_slot = 3'(cs); clr_port = 3'(cp);
        @(negedge clk);
        set_vld = 0; clr_vld = 0;
        if (cv && cs < 7) m_st[word_of(cs)][base_of(cs)+cp] = 1'b0;
        if (sv && ss < 7) m_st[word_of(ss)][base_of(ss)+sp] = 1'b1;
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
        if (a == 8'h20) m_mk[0] = d;
        if (a == 8'h28) m_mk[1] = d;
    endtask

    task automatic bus_read(string req, logic [7:0] a);
        @(negedge clk);
        bus_addr = a; bus_re = 1;
        @(negedge clk);
        bus_re = 0;
        check(req, bus_rdata, exp_read(a));
    endtask

    // irq is registered from registered state: one idle cycle after any change
    task automatic irq_check(string req);
        @(negedge clk);
        check(req, {31'b0, irq}, {31'b0, exp_irq()});
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] st1_snap;
        logic [31:0] st0_snap;
        void'($urandom(32'd20240611));
        m_st[0] = 0; m_st[1] = 0; m_mk[0] = 0; m_mk[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R8 reset state
        check("R8 irq", {31'b0, irq}, 32'h0);
        bus_read("R8 status0", 8'h10);
        bus_read("R8 status1", 8'h18);
        bus_read("R8 mask0", 8'h20);
        bus_read("R8 mask1", 8'h28);

        // R1/R2 lane map: set port 0 and port 7 of each slot one at a time
        for (int s = 0; s < 7; s++) begin
            request(1, s, 0, 0, 0, 0);
            request(1, s, 7, 0, 0, 0);
            bus_read((word_of(s) == 0) ? "R1 lane map" : "R2 lane map",
                     (word_of(s) == 0) ? 8'h10 : 8'h18);
        end
        // R2 all ports of all slots: lane 0 of word 1 must be empty
        for (int s = 0; s < 7; s++)
            for (int p = 0; p < 8; p++)
                request(1, s, p, 0, 0, 0);
        bus_read("R1 full word0", 8'h10);
        bus_read("R2 full word1", 8'h18);
        check("R2 lane0 empty", {24'b0, bus_rdata[7:0]}, 32'h0);
        // R5 aliases
        bus_read("R5 alias 0x11", 8'h11);
        bus_read("R5 alias 0x13", 8'h13);
        bus_read("R5 alias 0x1A", 8'h1A);
        bus_read("R5 alias 0x1B", 8'h1B);

        // R3 clear, and set wins on the same bit
        request(0, 0, 0, 1, 3, 5);
        bus_read("R3 clear", 8'h10);
        request(1, 6, 2, 1, 6, 2);
        bus_read("R3 set wins", 8'h18);
        request(1, 1, 1, 1, 5, 4);
        bus_read("R3 dual set", 8'h10);
        bus_read("R3 dual clear", 8'h18);

        // R5 bus writes to status do nothing
        bus_write(8'h10, 32'h0);
        bus_write(8'h1B, 32'h0);
        bus_read("R5 write ignored w0", 8'h10);
        bus_read("R5 write ignored w1", 8'h18);

        // clear everything
        for (int s = 0; s < 7; s++)
            for (int p = 0; p < 8; p++)
                request(0, 0, 0, 1, s, p);
        bus_read("R3 all cleared w0", 8'h10);
        bus_read("R3 all cleared w1", 8'h18);

        // R4 slot 7 ignored, on both channels
        request(1, 2, 3, 0, 0, 0);
        st0_snap = m_st[0]; st1_snap = m_st[1];
        request(1, 7, 4, 0, 0, 0);
        request(0, 0, 0, 1, 7, 3);
        bus_read("R4 slot7 w0", 8'h10);
        bus_read("R4 slot7 w1", 8'h18);
        check("R4 model unchanged", m_st[1], st1_snap);

        // R6 masks and R9 unmapped
        bus_write(8'h20, 32'hA5A5_0F0F);
        bus_write(8'h28, 32'h1234_5678);
        bus_read("R6 mask0", 8'h20);
        bus_read("R6 mask1", 8'h28);
        bus_write(8'h21, 32'hFFFF_FFFF);
        bus_read("R9 0x21", 8'h21);
        bus_read("R9 0x29", 8'h29);
        bus_read("R9 0x30", 8'h30);
        bus_read("R9 0x7C", 8'h7C);
        bus_read("R6 mask0 after 0x21 write", 8'h20);

        // R7 directed: mask edge
        bus_write(8'h28, 32'h0);
        bus_write(8'h20, 32'h0);
        irq_check("R7 masked off");
        bus_write(8'h28, 32'h0000_0800);  // slot 2 port 3
        check("R7 latency: not yet", {31'b0, irq}, 32'h0);
        irq_check("R7 mask on");
        request(0, 0, 0, 1, 2, 3);
        check("R7 latency: still high", {31'b0, irq}, 32'h1);
        irq_check("R7 clear drops");

        // R10: read reflects state before the edge
        @(negedge clk);
        set_vld = 1; set_slot = 3'd0; set_port = 3'd2;
        bus_addr = 8'h10; bus_re = 1;
        @(negedge clk);
        set_vld = 0; bus_re = 0;
        check("R10 old value", bus_rdata, m_st[0]);
        m_st[0][2] = 1'b1;
        bus_read("R10 new value", 8'h10);

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0, 1: request(1, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                              $urandom_range(0, 1) == 1,
                              int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
                2:    request(0, 0, 0, 1, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
                3:    bus_write(($urandom_range(0, 1) == 1) ? 8'h20 : 8'h28,
                                $urandom() & $urandom());
                4:    bus_read("R5/R6 random read",
                               8'((($urandom_range(0, 5)) << 3) + 8'h10 + $urandom_range(0, 3)));
                default: bus_write(8'h10 + 8'($urandom_range(0, 11)), $urandom());
            endcase
            irq_check("R7 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule